// File: doc/BRIEF.md
# Wake-Up Request Collector

This block gathers wake-up causes for a low-power system and turns them into one wake request and one interrupt request. There are three kinds of source. Four external pins can each be set to detect an edge or a level, with their own polarity. A free-running wake timer is compared with a programmable timeout. A single-cycle match strobe arrives from a real-time counter.

Each source has a wake-enable bit and a separate interrupt-enable bit. Every event is latched into a sticky status flag. Software clears a flag by writing a 1 to its bit. The current sleep state is an input to the block. When a source fires during hibernate or during doze, a separate status bit records that state. Sequencing of power, regulators and sleep modes is handled outside this block.

A four-word register bus carries the control word, the status word, the timer count and the timer timeout. Writes take effect at the clock edge. Reads are combinational.

Top module: `wkup_ctrl`

## Requirements
- R1: The control word (address 0) resets to zero. Only these bits can be written: 0 (timer wake enable), 1 (real-time wake enable), 7:4 (pin enables), 11:8 (pin edge select, 1 = edge), 15:12 (pin polarity, 1 = high/rising), 16 (timer interrupt enable), 17 (real-time interrupt enable) and 23:20 (pin interrupt enables). All other bits read 0, so the writable mask is 0x00F3FFF3. The timeout (address 3) reads back as written.
- R2: In edge mode an enabled pin fires only on its active edge: rising when polarity is 1, falling when polarity is 0. Pin i sets status bit 4+i.
- R3: In level mode an enabled pin fires on every cycle in which its synchronised value equals its polarity. Its flag therefore cannot be cleared while the level persists, and it can be cleared once the level goes away.
- R4: A pin whose enable bit is 0 sets no flag and raises no wake request, whatever it does.
- R5: The timer count (address 2) goes up by one each clock cycle. A write to address 2 loads the count. When the count equals the timeout and bit 0 is set, the timer fires and sets status bit 0.
- R6: With bit 1 set, a real-time match strobe fires in the same cycle and sets status bit 3. With bit 1 clear, the strobe has no effect.
- R7: The status word (address 1) clears each flag written with 1 and leaves each flag written with 0 unchanged.
- R8: When a flag is set and cleared in the same cycle, it ends up set.
- R9: `irq` is high whenever some flag among bits 0, 3 and 7:4 is set and its interrupt enable (16, 17, 23:20) is 1. It is low otherwise.
- R10: `wake_req` is high in exactly the cycles in which an enabled source fires. The interrupt enables have no effect on it.
- R11: A firing while `sleep_state` is 1 (hibernate) sets status bit 1. A firing while `sleep_state` is 2 (doze) sets status bit 2.
- R12: A pin change shows on `wake_req` after two clock edges (two-flop synchroniser). The flag follows one edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | Write when high, together with bus_en |
| bus_addr | input | 2 | Word select: 0 control, 1 status, 2 count, 3 timeout |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| ext_wake_in | input | 4 | Asynchronous external wake pins |
| rtc_match | input | 1 | Real-time counter compare strobe, synchronous |
| sleep_state | input | 2 | 0 run, 1 hibernate, 2 doze |
| wake_req | output | 1 | Wake request |
| irq | output | 1 | Interrupt request |

## Verification
The properties assume that `rtc_match` and `sleep_state` are synchronous to `clk`. They also assume that only the pins pass through the synchroniser. The bench therefore changes every input at the falling edge and moves the pins only through the two-flop path. The count-progress property assumes that no load occurs in the checked cycle, so the bench loads the count only through single write transactions. Flag-clear checks are issued only when no source is firing, except in the deliberate set-versus-clear case with a held level.

// File: rtl/wkup_pkg.sv
package wkup_pkg;

    localparam int EXT_N  = 4;
    localparam int DATA_W = 32;
    localparam int STAT_W = 8;

    localparam logic [DATA_W-1:0] CTRL_MASK = 32'h00F3_FFF3;

    typedef enum logic [1:0] {
        SLP_RUN  = 2'd0,
        SLP_HIB  = 2'd1,
        SLP_DOZE = 2'd2
    } sleep_e;

    typedef enum logic [1:0] {
        A_CTRL = 2'd0,
        A_STAT = 2'd1,
        A_CNT  = 2'd2,
        A_TMO  = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic [7:0]       rsv_hi;
        logic [EXT_N-1:0] pin_ien;
        logic [1:0]       rsv_mid;
        logic             rtc_ien;
        logic             tmr_ien;
        logic [EXT_N-1:0] pin_pol;
        logic [EXT_N-1:0] pin_edge;
        logic [EXT_N-1:0] pin_en;
        logic [1:0]       rsv_lo;
        logic             rtc_en;
        logic             tmr_en;
    } ctrl_t;

    typedef struct packed {
        logic [EXT_N-1:0] pin_evt;
        logic             rtc_evt;
        logic             doze_evt;
        logic             hib_evt;
        logic             tmr_evt;
    } stat_t;

    function automatic ctrl_t ctrl_from_word(input logic [DATA_W-1:0] w);
        return ctrl_t'(w & CTRL_MASK);
    endfunction

    function automatic logic pin_hit(input logic edge_mode, input logic pol,
                                     input logic cur, input logic prev);
        if (edge_mode)
            return pol ? (cur & ~prev) : (~cur & prev);
        return cur == pol;
    endfunction

endpackage

// File: rtl/wkup_ext_line.sv
module wkup_ext_line
    import wkup_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin,
    input  logic en,
    input  logic edge_mode,
    input  logic pol,
    output logic fire
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;
    logic                   cur;

    assign cur = sync_q[SYNC_STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], pin};
            prev_q <= cur;
        end
    end

    assign fire = en & pin_hit(edge_mode, pol, cur, prev_q);
endmodule

// File: rtl/wkup_timer.sv
module wkup_timer #(
    parameter int TMR_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             load,
    input  logic [TMR_W-1:0] load_val,
    input  logic [TMR_W-1:0] timeout,
    output logic [TMR_W-1:0] count,
    output logic             fire
);
    logic [TMR_W-1:0] count_q;

    always_ff @(posedge clk) begin
        if (rst)
            count_q <= '0;
        else if (load)
            count_q <= load_val;
        else
            count_q <= count_q + TMR_W'(1);
    end

    assign count = count_q;
    assign fire  = en & (count_q == timeout);
endmodule

// File: rtl/wkup_status.sv
module wkup_status
    import wkup_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clr_we,
    input  logic [STAT_W-1:0] clr_bits,
    input  stat_t             set_evt,
    input  logic [STAT_W-1:0] ien_mask,
    output stat_t             status,
    output logic              irq
);
    stat_t             stat_q;
    logic [STAT_W-1:0] clr_eff;

    assign clr_eff = clr_we ? clr_bits : '0;

    always_ff @(posedge clk) begin
        if (rst)
            stat_q <= '0;
        else
            stat_q <= stat_t'((stat_q & ~clr_eff) | set_evt);
    end

    assign status = stat_q;
    assign irq    = |(stat_q & ien_mask);
endmodule

// File: rtl/wkup_ctrl.sv
module wkup_ctrl
    import wkup_pkg::*;
#(
    parameter int TMR_W       = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [1:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [EXT_N-1:0]  ext_wake_in,
    input  logic              rtc_match,
    input  logic [1:0]        sleep_state,
    output logic              wake_req,
    output logic              irq
);
    ctrl_t             ctrl_q;
    logic [TMR_W-1:0]  tmo_q;
    logic [TMR_W-1:0]  tmr_count;
    logic              tmr_fire;
    logic              rtc_fire;
    logic [EXT_N-1:0]  pin_fire;
    logic              any_fire;
    stat_t             stat_w;
    stat_t             set_evt;
    logic [STAT_W-1:0] ien_mask;
    logic              wr_ctrl, wr_stat, wr_cnt, wr_tmo;

    assign wr_ctrl = bus_en & bus_we & (bus_addr == A_CTRL);
    assign wr_stat = bus_en & bus_we & (bus_addr == A_STAT);
    assign wr_cnt  = bus_en & bus_we & (bus_addr == A_CNT);
    assign wr_tmo  = bus_en & bus_we & (bus_addr == A_TMO);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            tmo_q  <= '0;
        end else begin
            if (wr_ctrl) ctrl_q <= ctrl_from_word(bus_wdata);
            if (wr_tmo)  tmo_q  <= bus_wdata[TMR_W-1:0];
        end
    end

    for (genvar i = 0; i < EXT_N; i++) begin : g_pin
        wkup_ext_line #(.SYNC_STAGES(SYNC_STAGES)) u_line (
            .clk       (clk),
            .rst       (rst),
            .pin       (ext_wake_in[i]),
            .en        (ctrl_q.pin_en[i]),
            .edge_mode (ctrl_q.pin_edge[i]),
            .pol       (ctrl_q.pin_pol[i]),
            .fire      (pin_fire[i])
        );
    end

    wkup_timer #(.TMR_W(TMR_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .en       (ctrl_q.tmr_en),
        .load     (wr_cnt),
        .load_val (bus_wdata[TMR_W-1:0]),
        .timeout  (tmo_q),
        .count    (tmr_count),
        .fire     (tmr_fire)
    );

    assign rtc_fire = ctrl_q.rtc_en & rtc_match;
    assign any_fire = tmr_fire | rtc_fire | (|pin_fire);

    always_comb begin
        set_evt          = '0;
        set_evt.pin_evt  = pin_fire;
        set_evt.rtc_evt  = rtc_fire;
        set_evt.tmr_evt  = tmr_fire;
        set_evt.hib_evt  = any_fire & (sleep_state == SLP_HIB);
        set_evt.doze_evt = any_fire & (sleep_state == SLP_DOZE);
    end

    assign ien_mask = {ctrl_q.pin_ien, ctrl_q.rtc_ien, 2'b00, ctrl_q.tmr_ien};

    wkup_status u_status (
        .clk      (clk),
        .rst      (rst),
        .clr_we   (wr_stat),
        .clr_bits (bus_wdata[STAT_W-1:0]),
        .set_evt  (set_evt),
        .ien_mask (ien_mask),
        .status   (stat_w),
        .irq      (irq)
    );

    assign wake_req = any_fire;

    always_comb begin
        unique case (bus_addr)
            A_CTRL:  bus_rdata = ctrl_q;
            A_STAT:  bus_rdata = DATA_W'(stat_w);
            A_CNT:   bus_rdata = DATA_W'(tmr_count);
            default: bus_rdata = DATA_W'(tmo_q);
        endcase
    end
endmodule

// File: rtl/wkup_checker.sv
module wkup_checker
    import wkup_pkg::*;
#(
    parameter int TMR_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_en,
    input logic              bus_we,
    input logic [1:0]        bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] ctrl,
    input logic [STAT_W-1:0] status,
    input logic [TMR_W-1:0]  count,
    input logic [1:0]        sleep_state,
    input logic              wake_req,
    input logic              irq
);
    AST_CTRL_MASKED: assert property (@(posedge clk) disable iff (rst)
        (bus_en && bus_we && bus_addr == 2'd0) |=> ctrl == ($past(bus_wdata) & CTRL_MASK)); // R1

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
        !(bus_en && bus_we && bus_addr == 2'd2) |=> count == $past(count) + TMR_W'(1)); // R5

    AST_W1C_ALL: assert property (@(posedge clk) disable iff (rst)
        (bus_en && bus_we && bus_addr == 2'd1 && bus_wdata[7:0] == 8'hFF && !wake_req)
        |=> status == 8'h00); // R7

    AST_FIRE_LATCHES: assert property (@(posedge clk) disable iff (rst)
        wake_req |=> status != 8'h00); // R10

    AST_IRQ_NEEDS_IEN: assert property (@(posedge clk) disable iff (rst)
        (ctrl[23:20] == 4'h0 && ctrl[17:16] == 2'b00) |-> !irq); // R9

    AST_HIB_MARK: assert property (@(posedge clk) disable iff (rst)
        (wake_req && sleep_state == 2'd1) |=> status[1]); // R11

    AST_DOZE_MARK: assert property (@(posedge clk) disable iff (rst)
        (wake_req && sleep_state == 2'd2) |=> status[2]); // R11
endmodule

bind wkup_ctrl wkup_checker #(.TMR_W(TMR_W)) u_wkup_chk (
    .clk         (clk),
    .rst         (rst),
    .bus_en      (bus_en),
    .bus_we      (bus_we),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .ctrl        (ctrl_q),
    .status      (stat_w),
    .count       (tmr_count),
    .sleep_state (sleep_state),
    .wake_req    (wake_req),
    .irq         (irq)
);

// File: tb/tb_wkup_ctrl.sv
module tb_wkup_ctrl;
    logic        clk = 1'b0;
    logic        rst;
    logic        bus_en, bus_we;
    logic [1:0]  bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic [3:0]  ext_wake_in;
    logic        rtc_match;
    logic [1:0]  sleep_state;
    logic        wake_req, irq;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    always #10 clk = ~clk;

    wkup_ctrl dut (
        .clk(clk), .rst(rst), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ext_wake_in(ext_wake_in), .rtc_match(rtc_match),
        .sleep_state(sleep_state), .wake_req(wake_req), .irq(irq)
    );

    // {addr, write data, expected read-back}
    localparam logic [65:0] VEC [6] = '{
        {2'd0, 32'hFFFF_FFFF, 32'h00F3_FFF3},
        {2'd0, 32'h0000_000C, 32'h0000_0000},
        {2'd0, 32'h1234_5678, 32'h0030_5670},
        {2'd3, 32'hA5A5_A5A5, 32'hA5A5_A5A5},
        {2'd0, 32'h0000_0000, 32'h0000_0000},
        {2'd1, 32'h0000_0000, 32'h0000_0000}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        logic        seen;
        rst = 1'b1; bus_en = 0; bus_we = 0; bus_addr = 0; bus_wdata = 0;
        ext_wake_in = 0; rtc_match = 0; sleep_state = 0;
        wait_n(3);
        rst = 1'b0;
        wait_n(1);

        // reset state
        rd(0, r); check("R1 ctrl reset", r, 0);
        rd(1, r); check("R7 status reset", r, 0);
        check("R10 wake reset", {31'b0, wake_req}, 0);
        check("R9 irq reset", {31'b0, irq}, 0);

        // R1 register table
        for (int i = 0; i < 6; i++) begin
            wr(VEC[i][65:64], VEC[i][63:32]);
            rd(VEC[i][65:64], r);
            check("R1 readback", r, VEC[i][31:0]);
        end

        // R2/R12 pin 0 rising edge
        wr(0, 32'h0000_1110);
        ext_wake_in[0] = 1'b1;
        wait_n(1); check("R12 no wake after one edge", {31'b0, wake_req}, 0);
        wait_n(1); check("R12 wake after two edges", {31'b0, wake_req}, 1);
        wait_n(1); check("R2 edge single pulse", {31'b0, wake_req}, 0);
        rd(1, r); check("R2 pin0 flag", r, 32'h10);
        wr(1, 32'hFF);
        ext_wake_in[0] = 1'b0;
        wait_n(4); rd(1, r); check("R2 falling ignored with pol 1", r, 0);

        // R2 pin 1 falling edge
        wr(0, 32'h0000_0220);
        ext_wake_in[1] = 1'b1;
        wait_n(4); rd(1, r); check("R2 rising ignored with pol 0", r, 0);
        ext_wake_in[1] = 1'b0;
        wait_n(4); rd(1, r); check("R2 falling edge pin1", r, 32'h20);
        wr(1, 32'hFF);
        rd(1, r); check("R7 clear pin1", r, 0);

        // R3/R8/R9 pin 2 level high
        wr(0, 32'h0000_4040);
        ext_wake_in[2] = 1'b1;
        wait_n(4); rd(1, r); check("R3 level flag", r, 32'h40);
        check("R3 wake held", {31'b0, wake_req}, 1);
        wr(1, 32'h40);
        rd(1, r); check("R8 set beats clear", r, 32'h40);
        check("R9 irq off without ien", {31'b0, irq}, 0);
        wr(0, 32'h0040_4040);
        wait_n(1); check("R9 irq with pin ien", {31'b0, irq}, 1);
        ext_wake_in[2] = 1'b0;
        wait_n(4); check("R3 wake drops", {31'b0, wake_req}, 0);
        wr(1, 32'h40);
        rd(1, r); check("R3 clear after level gone", r, 0);
        check("R9 irq falls", {31'b0, irq}, 0);

        // R4 disabled pin 3
        wr(0, 32'h0000_8800);
        seen = 1'b0;
        ext_wake_in[3] = 1'b1;
        for (int k = 0; k < 4; k++) begin @(negedge clk); seen |= wake_req; end
        ext_wake_in[3] = 1'b0;
        for (int k = 0; k < 4; k++) begin @(negedge clk); seen |= wake_req; end
        check("R4 no wake when disabled", {31'b0, seen}, 0);
        rd(1, r); check("R4 no flag when disabled", r, 0);

        // R5/R11 timer in hibernate
        sleep_state = 2'd1;
        wr(3, 32'd20);
        wr(0, 32'h0001_0001);
        wr(1, 32'hFF);
        wr(2, 32'd0);
        rd(2, r); check("R5 count loaded", r, 0);
        wait_n(5);
        rd(2, r); check("R5 count increments", r, 5);
        wait_n(14); check("R5 no fire before match", {31'b0, wake_req}, 0);
        wait_n(1);  check("R10 wake on timer match", {31'b0, wake_req}, 1);
        wait_n(1);  rd(1, r); check("R11 timer and hibernate flags", r, 32'h03);
        check("R9 irq timer ien", {31'b0, irq}, 1);
        sleep_state = 2'd0;
        wr(0, 32'h0);
        wr(1, 32'hFF);
        rd(1, r); check("R7 clear all", r, 0);

        // R6/R11 real-time match in doze
        sleep_state = 2'd2;
        wr(0, 32'h0000_0002);
        rtc_match = 1'b1;
        #1 check("R6 R10 wake on rtc without ien", {31'b0, wake_req}, 1);
        @(negedge clk);
        rtc_match = 1'b0;
        rd(1, r); check("R6 R11 rtc and doze flags", r, 32'h0C);
        check("R9 no irq without ien", {31'b0, irq}, 0);
        wr(1, 32'h00);
        rd(1, r); check("R7 write zero keeps", r, 32'h0C);
        wr(1, 32'h08);
        rd(1, r); check("R7 selective clear", r, 32'h04);
        wr(1, 32'h04);
        sleep_state = 2'd0;
        wr(0, 32'h0);
        rtc_match = 1'b1;
        #1 check("R6 disabled no wake", {31'b0, wake_req}, 0);
        @(negedge clk);
        rtc_match = 1'b0;
        rd(1, r); check("R6 disabled no flag", r, 0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule